// File: doc/BRIEF.md
# Windowed DMA Address Walker

This block produces the memory address for one side of a DMA channel, either the read side or the write side. In linear operation it behaves like an ordinary incrementing pointer. Each accepted beat moves the address forward by the beat width in bytes. In window mode it walks a rectangle cut out of a wider image held in memory. The walk starts at a programmed start address inside the image and moves along a row one beat at a time. After a programmed number of beats it skips over the part of the image row that lies outside the window, so that the next beat lands on the first pixel of the window's next row.

Software programs four things for window mode. The window width is the row length in beats. The skip amount is the image width minus the window width, in bytes. The beat width and the start address complete the setup. Software then pulses the load strobe. The channel pulses the beat strobe once for each transfer it completes, and the address output always shows where the next transfer goes. Bus transactions, pixel formats and end-of-transfer detection are outside this block.

Top module: `pip_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the address output is zero.
- R2: A load pulse sets the address to the start address in the next cycle and starts a new row. Load takes priority over a beat in the same cycle.
- R3: With window mode inactive, each beat adds 2^size bytes to the address. The size field is encoded as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.
- R4: In a cycle with neither load nor beat, the address does not change.
- R5: With window mode active (enable high and row length nonzero), the beat that completes a row adds the beat width plus the skip amount. A row is complete after the row-length count of beats since the last load or the last skip.
- R6: After a skip the row count restarts, so every later row also takes exactly row-length beats, and each beat that does not complete a row adds only the beat width.
- R7: A row length of zero disables window mode even with enable high, so no skip is ever added.
- R8: With enable low the address advances linearly. The row count is held at zero, so after enable is raised again the next row starts fresh.
- R9: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load the start address and clear the row count |
| beat_i | input | 1 | One transfer completed; advance the address |
| win_en_i | input | 1 | Window mode enable |
| size_i | input | 2 | Beat width as log2 of the byte count |
| start_addr_i | input | ADDR_W | First address of the window |
| row_len_i | input | CNT_W | Beats per window row; 0 disables window mode |
| skip_i | input | ADDR_W | Bytes skipped at each row end |
| addr_o | output | ADDR_W | Address for the next transfer |

## Verification
The bench goes after the row-end beat. A counter that is off by one would add the skip one beat early or one beat late, which displaces every following row. Row length 1 puts a skip on every beat and exposes a counter that fails to restart. A row length of zero with enable high would, in a design that fails to gate it, add the skip at a wrapped counter value. Other cases covered:
- Toggling enable in the middle of a row catches a count left stale instead of cleared.
- A load together with a beat catches wrong priority, where the address ends up one step past the start.
- A start near the top of the address space catches arithmetic that does not wrap.

// File: rtl/pip_addr_pkg.sv
package pip_addr_pkg;

    typedef enum logic [1:0] {
        BEAT_1B = 2'd0,
        BEAT_2B = 2'd1,
        BEAT_4B = 2'd2,
        BEAT_8B = 2'd3
    } beat_size_e;

endpackage

// File: rtl/pip_step_decode.sv
module pip_step_decode #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic [SIZE_W-1:0] size_i,
    output logic [ADDR_W-1:0] step_o
);
    localparam int N_SIZES = 1 << SIZE_W;

    logic [N_SIZES-1:0][ADDR_W-1:0] step_tab;

    for (genvar g = 0; g < N_SIZES; g++) begin : g_step
        assign step_tab[g] = ADDR_W'(1) << g;
    end

    always_comb begin
        step_o = step_tab[size_i];
    end
endmodule

// File: rtl/pip_row_counter.sv
module pip_row_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             beat_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] row_len_i,
    output logic             row_end_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             at_end;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + CNT_W'(1);
        at_end  = active_i && (cnt_inc == row_len_i);
        if (load_i || !active_i) begin
            st_d.cnt = '0;
        end else if (beat_i) begin
            st_d.cnt = at_end ? '0 : cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_end_o = at_end && beat_i && !load_i;
    assign cnt_o     = st_q.cnt;
endmodule

// File: rtl/pip_addr_gen.sv
module pip_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              beat_i,
    input  logic              win_en_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  row_len_i,
    input  logic [ADDR_W-1:0] skip_i,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } addr_state_t;

    addr_state_t       st_d, st_q;
    logic [ADDR_W-1:0] step;
    logic              win_active;
    logic              row_end;
    logic [CNT_W-1:0]  row_cnt;

    assign win_active = win_en_i && (row_len_i != '0);

    pip_step_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_step (
        .size_i (size_i),
        .step_o (step)
    );

    pip_row_counter #(.CNT_W(CNT_W)) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .beat_i    (beat_i),
        .active_i  (win_active),
        .row_len_i (row_len_i),
        .row_end_o (row_end),
        .cnt_o     (row_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.addr = start_addr_i;
        end else if (beat_i) begin
            st_d.addr = st_q.addr + step + (row_end ? skip_i : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
endmodule

// File: rtl/pip_addr_gen_chk.sv
module pip_addr_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12,
    parameter int SIZE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              beat_i,
    input logic              win_en_i,
    input logic [SIZE_W-1:0] size_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic [CNT_W-1:0]  row_len_i,
    input logic [ADDR_W-1:0] skip_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              row_end,
    input logic [CNT_W-1:0]  row_cnt
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> addr_o == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(start_addr_i));

    assert_plain_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && !load_i && !row_end)
        |=> addr_o == $past(addr_o) + (ADDR_W'(1) << $past(size_i)));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_i && !load_i) |=> $stable(addr_o));

    assert_row_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        row_end |=> addr_o == $past(addr_o) + (ADDR_W'(1) << $past(size_i)) + $past(skip_i));

    assert_row_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_end |=> row_cnt == '0);

    assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_len_i == '0) |-> !row_end);

    assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en_i |=> row_cnt == '0);
endmodule

bind pip_addr_gen pip_addr_gen_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .beat_i       (beat_i),
    .win_en_i     (win_en_i),
    .size_i       (size_i),
    .start_addr_i (start_addr_i),
    .row_len_i    (row_len_i),
    .skip_i       (skip_i),
    .addr_o       (addr_o),
    .row_end      (row_end),
    .row_cnt      (row_cnt)
);

// File: tb/pip_addr_gen_tb_top.sv
module pip_addr_gen_tb_top;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load = 1'b0;
    logic              beat = 1'b0;
    logic              win_en = 1'b0;
    logic [1:0]        size = 2'd0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  row_len = '0;
    logic [ADDR_W-1:0] skip = '0;
    logic [ADDR_W-1:0] addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bit [ADDR_W-1:0] exp_addr = '0;
    int              exp_cnt  = 0;
    string           tag      = "R1";

    always #4 clk = ~clk;

    pip_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SIZE_W(2)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .beat_i       (beat),
        .win_en_i     (win_en),
        .size_i       (size),
        .start_addr_i (start_addr),
        .row_len_i    (row_len),
        .skip_i       (skip),
        .addr_o       (addr)
    );

    task automatic cyc();
        bit [ADDR_W-1:0] st;
        bit              act;
        @(posedge clk);
        cycles++;
        st  = ADDR_W'(1) << size;
        act = win_en && (row_len != 0);
        if (!rst_n) begin
            exp_addr = '0; exp_cnt = 0; tag = "R1";
        end else if (load) begin
            exp_addr = start_addr; exp_cnt = 0; tag = "R2";
        end else if (beat) begin
            if (act && (exp_cnt + 1 == int'(row_len))) begin
                tag = (exp_addr + st + skip < exp_addr) ? "R9" : "R5";
                exp_addr = exp_addr + st + skip;
                exp_cnt = 0;
            end else begin
                if (exp_addr + st < exp_addr) tag = "R9";
                else if (act) tag = "R6";
                else if (win_en) tag = "R7";
                else tag = "R3";
                exp_addr = exp_addr + st;
                exp_cnt = act ? exp_cnt + 1 : 0;
            end
        end else begin
            tag = win_en ? "R4" : "R8";
            if (!act) exp_cnt = 0;
        end
        @(negedge clk);
        checks++;
        if (addr !== exp_addr) begin
            errors++;
            $display("FAIL %s addr actual %h expected %h", tag, addr, exp_addr);
        end
    endtask

    task automatic do_load(input bit [ADDR_W-1:0] a, input bit with_beat);
        load = 1'b1; beat = with_beat; start_addr = a;
        cyc();
        load = 1'b0; beat = 1'b0;
    endtask

    task automatic beats(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            beat = 1'b1;
            cyc();
            beat = 1'b0;
            if (gaps && ($urandom % 3 == 0)) cyc();
        end
    endtask

    initial begin
        repeat (3) cyc();                       // R1 during reset
        rst_n = 1'b1;
        cyc();                                  // R1 first cycle after
        // R3, R4, R8: linear walk, mixed sizes
        do_load(32'h0000_1000, 1'b0);
        for (int s = 0; s < 4; s++) begin
            size = 2'(s);
            beats(3, 1'b1);
            cyc();
        end
        // R5, R6: window 4 beats wide, 0x40 byte skip
        win_en = 1'b1; row_len = 12'd4; skip = 32'h40; size = 2'd2;
        do_load(32'h0000_2000, 1'b0);
        beats(14, 1'b1);
        // R5/R6 row length 1: skip on every beat
        row_len = 12'd1; skip = 32'h8; size = 2'd0;
        do_load(32'h0000_3000, 1'b0);
        beats(5, 1'b0);
        // R7: zero row length with enable high
        row_len = 12'd0; skip = 32'h100;
        do_load(32'h0000_4000, 1'b0);
        beats(10, 1'b1);
        // R8: drop enable in mid-row, then raise it again
        row_len = 12'd5; size = 2'd1; skip = 32'h20;
        do_load(32'h0000_5000, 1'b0);
        beats(3, 1'b0);
        win_en = 1'b0;
        beats(2, 1'b0);
        cyc();
        win_en = 1'b1;
        beats(11, 1'b1);
        // R2: load with simultaneous beat, also mid-row
        beats(2, 1'b0);
        do_load(32'h0000_6000, 1'b1);
        beats(6, 1'b0);
        // R9: wrap near top of address space, linear and with skip
        win_en = 1'b0; size = 2'd3;
        do_load(32'hFFFF_FFF0, 1'b0);
        beats(4, 1'b0);
        win_en = 1'b1; row_len = 12'd2; skip = 32'h10;
        do_load(32'hFFFF_FFE0, 1'b0);
        beats(6, 1'b0);
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            load   = ($urandom % 23 == 0);
            beat   = ($urandom % 3 != 0);
            if ($urandom % 37 == 0) win_en = ~win_en;
            if ($urandom % 41 == 0) row_len = 12'($urandom % 6);
            if ($urandom % 29 == 0) size = 2'($urandom);
            start_addr = $urandom;
            skip = 32'($urandom % 512);
            cyc();
        end
        load = 1'b0; beat = 1'b0;
        cyc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual %0d cycles expected completion", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule